// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches eight external interrupt pins and turns activity on each of them into a latched, active-high level request for a parent interrupt controller. Each pin is first brought into the clock domain through a two-flop synchroniser. It is then judged against a 2-bit sense mode: low level, falling edge, rising edge, or both edges. The result drives that pin's status bit. The status bit is driven straight out as the pin's interrupt request.

Software sees two 32-bit registers through a plain strobe interface, with a write enable, a read enable, a byte address and data. The sense-mode register is at offset 0x14. The status register is at offset 0x10. In an edge mode, a status bit stays set until software writes a 0 to it. In low-level mode, the bit simply follows the inverted pin and cannot be cleared. Reads return data in the same cycle the read enable is high.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset every sense field reads 0, every status bit reads 0, and every interrupt output is low.
- R2: The sense register at offset 0x14 holds pin n's mode in bits [2n+1:2n]. It reads back what was written, and bits 31:16 read 0.
- R3: In falling-edge mode (code 1), a high-to-low transition of the pin sets its status bit. A low-to-high transition does not.
- R4: In rising-edge mode (code 2), a low-to-high transition of the pin sets its status bit. A high-to-low transition does not.
- R5: In both-edges mode (code 3), either transition of the pin sets its status bit.
- R6: In low-level mode (code 0), the status bit equals the inverted synchronised pin. Writing 0 to that bit has no effect.
- R7: In an edge mode, writing 0 to a status bit at offset 0x10 clears it. Writing 1 leaves it unchanged.
- R8: If a qualifying edge lands in the same cycle as a clear of its bit, the bit stays set.
- R9: Each interrupt output is high exactly while its status bit is set.
- R10: Writing the sense register never sets a status bit by itself.
- R11: The status register reads at offset 0x10 with bits 31:8 zero. Reads of any other offset return 0. The read data is 0 while the read enable is low.
- R12: A pin transition shows on its status bit and interrupt output at the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinIn | input | 8 | Asynchronous external interrupt pins |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while rdEn is high |
| irqOut | output | 8 | Active-high level request per pin |

## Verification
The bench sweeps every pin through every sense mode. For each combination it drives a fall and then a rise, and after each step it tries both a write of ones and a write of zeros to the status register. This catches a swapped mode code, an edge polarity reversed, a status bit that can be cleared in low-level mode, or a bit that a write of 1 disturbs.

Two timing cases get their own stimulus. First, a clear timed to land in the same cycle as a fresh rising edge: a design that lets the clear win would drop a real interrupt. Second, the exact three-edge latency from pin to output: a missing or extra synchroniser stage would show the request one cycle early or late.

Writes to the sense register are checked to see whether they raise any request. Reads at an unmapped offset, or with the read enable low, are checked to see whether they leak register contents.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL_LOW = 2'd0,
    SENSE_FALL      = 2'd1,
    SENSE_RISE      = 2'd2,
    SENSE_BOTH      = 2'd3
  } sense_e;

  // Write strobes from the register decoder to the datapath
  typedef struct packed {
    logic statusWr;
    logic senseWr;
  } regStrobe_t;

endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 'h10,
  parameter int SENSE_OFS  = 'h14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_PINS-1:0]   statusQ,
  input  logic [2*NUM_PINS-1:0] senseQ,
  output regStrobe_t            strobe,
  output logic [DATA_W-1:0]     rdData
);
  localparam int SENSE_W = 2 * NUM_PINS;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] SENSE_ADDR  = ADDR_W'(SENSE_OFS);

  logic hitStatus;
  logic hitSense;

  assign hitStatus = (addr == STATUS_ADDR);
  assign hitSense  = (addr == SENSE_ADDR);

  always_comb begin
    strobe.statusWr = wrEn && hitStatus;
    strobe.senseWr  = wrEn && hitSense;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (hitStatus)     rdData[NUM_PINS-1:0] = statusQ;
      else if (hitSense) rdData[SENSE_W-1:0]  = senseQ;
    end
  end

  // A sense write is visible in the datapath register on the next cycle
  assert_sense_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.senseWr |=> (senseQ == $past(wrData[SENSE_W-1:0])));

endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  regStrobe_t            strobe,
  input  logic [DATA_W-1:0]     wrData,
  output logic [NUM_PINS-1:0]   statusQ,
  output logic [2*NUM_PINS-1:0] senseQ
);
  localparam int SENSE_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] riseEv;
  logic [NUM_PINS-1:0] fallEv;
  logic [NUM_PINS-1:0] evt;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] statusNext;

  // Synchroniser chain, idles high so released pins raise nothing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= pinSync;
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign riseEv  = pinSync & ~prevQ;
  assign fallEv  = ~pinSync & prevQ;
  assign clrMask = strobe.statusWr ? ~wrData[NUM_PINS-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      unique case (sense_e'(senseQ[2*i +: 2]))
        SENSE_FALL: evt[i] = fallEv[i];
        SENSE_RISE: evt[i] = riseEv[i];
        SENSE_BOTH: evt[i] = riseEv[i] | fallEv[i];
        default:    evt[i] = 1'b0;
      endcase
      if (sense_e'(senseQ[2*i +: 2]) == SENSE_LEVEL_LOW)
        statusNext[i] = ~pinSync[i];
      else
        statusNext[i] = evt[i] | (statusQ[i] & ~clrMask[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      senseQ  <= '0;
    end else begin
      statusQ <= statusNext;
      if (strobe.senseWr) senseQ <= wrData[SENSE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPinChk
    assert_level_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (senseQ[2*g +: 2] == 2'd0) |=> (statusQ[g] == ~$past(pinSync[g])));

    assert_clear_edge_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((senseQ[2*g +: 2] != 2'd0) && clrMask[g] && !evt[g]) |=> !statusQ[g]);

    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((senseQ[2*g +: 2] != 2'd0) && evt[g]) |=> statusQ[g]);

    assert_no_spurious_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((senseQ[2*g +: 2] != 2'd0) && !evt[g] && !statusQ[g]) |=> !statusQ[g]);
  end

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_OFS  = 'h10,
  parameter int SENSE_OFS   = 'h14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] irqOut
);
  regStrobe_t            strobe;
  logic [NUM_PINS-1:0]   statusQ;
  logic [2*NUM_PINS-1:0] senseQ;

  pin_irq_ctrl #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_OFS(STATUS_OFS), .SENSE_OFS(SENSE_OFS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .statusQ(statusQ), .senseQ(senseQ),
    .strobe(strobe), .rdData(rdData)
  );

  pin_irq_datapath #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .strobe(strobe),
    .wrData(wrData), .statusQ(statusQ), .senseQ(senseQ)
  );

  assign irqOut = statusQ;

endmodule

// File: tb/pin_irq_sense_tb_top.sv
`timescale 1ns/1ps
module pin_irq_sense_tb_top;
  localparam logic [7:0] STATUS_A = 8'h10;
  localparam logic [7:0] SENSE_A  = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pinIn;
  logic        wrEn, rdEn;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic [7:0]  irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pin_irq_sense dut_i (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    #0.5;
    d = rdData;
    rdEn = 1'b0;
    #0.5;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    string lbl;
    rst_n = 1'b0; pinIn = '1; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    tick(3);
    rd(STATUS_A, d); check("R1 status", d, 32'h0);
    rd(SENSE_A, d);  check("R1 sense", d, 32'h0);
    check("R1 irq", {24'h0, irqOut}, 32'h0);
    rst_n = 1'b1;
    tick(4);
    check("R1 irq after release", {24'h0, irqOut}, 32'h0);

    // Sweep every pin through every mode
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 4; m++) begin
        lbl = (m == 0) ? "R6" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        wr(SENSE_A, 32'(m) << (2 * n));
        wr(STATUS_A, 32'h0);
        tick(3);
        check("R10 sense write sets nothing", {24'h0, irqOut}, 32'h0);
        pinIn[n] = 1'b0;
        tick(3);
        check({lbl, " after fall"}, {24'h0, irqOut}, 32'((m != 2) ? 1 : 0) << n);
        rd(STATUS_A, d);
        check("R9 irq equals status", d, {24'h0, irqOut});
        wr(STATUS_A, 32'hFFFF_FFFF);
        check("R7 write one keeps", {24'h0, irqOut}, 32'((m != 2) ? 1 : 0) << n);
        wr(STATUS_A, 32'h0);
        check((m == 0) ? "R6 clear ignored" : "R7 clear", {24'h0, irqOut},
              32'((m == 0) ? 1 : 0) << n);
        pinIn[n] = 1'b1;
        tick(3);
        check({lbl, " after rise"}, {24'h0, irqOut}, 32'((m >= 2) ? 1 : 0) << n);
        wr(STATUS_A, 32'h0);
        check("R7 final clear", {24'h0, irqOut}, 32'h0);
      end
    end

    // R12 latency on pin 0, rising mode
    wr(SENSE_A, 32'h2);
    pinIn[0] = 1'b0;
    tick(3);
    wr(STATUS_A, 32'h0);
    pinIn[0] = 1'b1;
    tick(2);
    check("R12 not before third edge", {31'h0, irqOut[0]}, 32'h0);
    tick();
    check("R12 at third edge", {31'h0, irqOut[0]}, 32'h1);

    // R8 clear in the same cycle as a new edge
    pinIn[0] = 1'b0;
    tick(3);
    wr(STATUS_A, 32'h0);
    check("R8 setup cleared", {31'h0, irqOut[0]}, 32'h0);
    pinIn[0] = 1'b1;
    tick(2);
    wr(STATUS_A, 32'h0);
    check("R8 edge beats clear", {31'h0, irqOut[0]}, 32'h1);
    wr(STATUS_A, 32'h0);
    check("R7 later clear", {31'h0, irqOut[0]}, 32'h0);

    // R11 readback decoding with status bit 0 set
    pinIn[0] = 1'b0; tick(3);
    pinIn[0] = 1'b1; tick(3);
    rd(STATUS_A, d);      check("R11 status read", d, 32'h1);
    rd(8'h18, d);         check("R11 unmapped read", d, 32'h0);
    addr = STATUS_A; #0.5;
    check("R11 rdEn low", rdData, 32'h0);

    // R2 field layout and upper bits
    wr(SENSE_A, 32'hDEAD_BEEF);
    rd(SENSE_A, d); check("R2 sense readback", d, 32'h0000_BEEF);
    wr(SENSE_A, 32'h0);
    rd(SENSE_A, d); check("R2 sense zero", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule